// File: doc/BRIEF.md
# Bitmask dictionary instruction decompressor

This block rebuilds 32-bit instructions from a variable-length compressed bitstream. Compressed memory words arrive over a valid/ready input and are packed, most significant bit first, into a 96-bit shift buffer. A 3-bit type tag at the head of the buffer selects how the entry is decoded:
- a raw instruction,
- a short index into a small table of frequent instructions,
- an index into a large table,
- a large-table index followed by a shifted two-bit XOR patch that repairs a near-miss.

Both tables are register arrays. They are filled through a plain write port before the stream starts.

Rebuilt instructions leave through a small output queue with a valid/ready handshake:
- `out_data` holds steady while `out_valid` is high and `out_ready` is low.
- When the queue is full, decoding stalls and no buffer bits are consumed.
- The input side asks for a new word (`in_ready` high) whenever fewer than 64 valid bits are buffered.
- Input words transfer on any edge where `in_valid` and `in_ready` are both high.

Top module: `bmd_decomp`

## Requirements
- R1: After a synchronous reset (`rst` high for at least one edge), `out_valid` is 0, `err` is 0 and `in_ready` is 1.
- R2: Tag 000 is followed by a 32-bit instruction that is output unchanged; the entry occupies 35 bits.
- R3: Tag 001 is followed by a 4-bit index; the output is the small-table word at that index, and the entry occupies 7 bits.
- R4: Tag 010 is followed by an 8-bit index; the output is the large-table word at that index, and the entry occupies 11 bits.
- R5: Tag 011 is followed by an 8-bit index, a 2-bit position p and a 2-bit pattern m. The output is the large-table word XOR (m << 2*p), and the entry occupies 15 bits.
- R6: Each input word is consumed from bit 31 down to bit 0, and entries may straddle word boundaries. Outputs appear in stream order with nothing lost or repeated, including when a word is taken in the same cycle as an entry is consumed.
- R7: `in_ready` is high exactly when fewer than 64 valid bits are buffered, so the buffer never holds more than 96 bits.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged. With the 4-entry queue full, no entry is decoded.
- R9: Tags 100 to 111 consume only their 3 tag bits and produce no output. They set `err`, which stays at 1 until reset.
- R10: With `tbl_we` high, `tbl_large`=0 writes `tbl_data` into the small table at `tbl_addr[3:0]`, and `tbl_large`=1 writes it into the large table at `tbl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Table write strobe |
| tbl_large | input | 1 | Table select: 0 small, 1 large |
| tbl_addr | input | 8 | Table write address |
| tbl_data | input | 32 | Table write data |
| in_valid | input | 1 | Compressed word valid |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | 32 | Compressed word, first bit in bit 31 |
| out_valid | output | 1 | Rebuilt instruction valid |
| out_ready | input | 1 | Consumer takes the instruction |
| out_data | output | 32 | Rebuilt instruction |
| err | output | 1 | Sticky reserved-tag flag |

## Verification
Two functions can share a clock edge: the buffer shifting out a consumed entry and the buffer appending a freshly accepted word at the new fill level. The bench provokes this by streaming a long mixed stream with input always offered and the output always ready. The stream sweeps every small index, every large index and every patch position and pattern. The same stream is then replayed with input gaps and pseudo-random output back-pressure. Each output is judged against a value the bench computes from the table formulas and the patch rule. Any misplaced append or shift shows as a wrong word or a shifted sequence.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int TAG_W  = 3;
  localparam int POS_W  = 2;
  localparam int MASK_W = 2;
  localparam logic [TAG_W-1:0] TAG_RAW   = 3'b000;
  localparam logic [TAG_W-1:0] TAG_SMALL = 3'b001;
  localparam logic [TAG_W-1:0] TAG_LARGE = 3'b010;
  localparam logic [TAG_W-1:0] TAG_PATCH = 3'b011;
endpackage

// File: rtl/bmd_table.sv
module bmd_table #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bmd_inbuf.sv
module bmd_inbuf #(
  parameter int BUF_W  = 96,
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              consume,
  input  logic [CNT_W-1:0]  take_len,
  output logic [BUF_W-1:0]  bits,
  output logic [CNT_W-1:0]  cnt
);
  localparam int REFILL = BUF_W - WORD_W;

  logic [BUF_W-1:0] buf_q, buf_d, kept;
  logic [CNT_W-1:0] cnt_q, cnt_d, rem;
  logic             accept;

  assign in_ready = (cnt_q < CNT_W'(REFILL));
  assign accept   = in_valid && in_ready;

  always_comb begin
    kept  = consume ? (buf_q << take_len) : buf_q;
    rem   = consume ? (cnt_q - take_len) : cnt_q;
    buf_d = kept;
    cnt_d = rem;
    if (accept) begin
      buf_d = kept | ({in_data, {(BUF_W-WORD_W){1'b0}}} >> rem);
      cnt_d = rem + CNT_W'(WORD_W);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else begin
      buf_q <= buf_d;
      cnt_q <= cnt_d;
    end
  end

  assign bits = buf_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/bmd_decode.sv
module bmd_decode
  import bmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SIDX_W = 4,
  parameter int LIDX_W = 8,
  parameter int CNT_W  = 7,
  parameter int HEAD_W = TAG_W + DATA_W
) (
  input  logic [HEAD_W-1:0] head,
  input  logic [DATA_W-1:0] small_word,
  input  logic [DATA_W-1:0] large_word,
  output logic [SIDX_W-1:0] s_idx,
  output logic [LIDX_W-1:0] l_idx,
  output logic [CNT_W-1:0]  len,
  output logic [DATA_W-1:0] word,
  output logic              bad
);
  localparam int LEN_RAW   = TAG_W + DATA_W;
  localparam int LEN_SMALL = TAG_W + SIDX_W;
  localparam int LEN_LARGE = TAG_W + LIDX_W;
  localparam int LEN_PATCH = LEN_LARGE + POS_W + MASK_W;

  logic [TAG_W-1:0]  tag;
  logic [DATA_W-1:0] payload, mask;
  logic [POS_W-1:0]  pos;
  logic [MASK_W-1:0] pat;

  assign tag     = head[HEAD_W-1 -: TAG_W];
  assign payload = head[DATA_W-1:0];
  assign s_idx   = payload[DATA_W-1 -: SIDX_W];
  assign l_idx   = payload[DATA_W-1 -: LIDX_W];
  assign pos     = payload[DATA_W-LIDX_W-1 -: POS_W];
  assign pat     = payload[DATA_W-LIDX_W-POS_W-1 -: MASK_W];
  assign mask    = DATA_W'(pat) << (int'(pos) * MASK_W);

  always_comb begin
    bad  = 1'b0;
    word = payload;
    len  = CNT_W'(LEN_RAW);
    case (tag)
      TAG_RAW:   begin word = payload;           len = CNT_W'(LEN_RAW);   end
      TAG_SMALL: begin word = small_word;        len = CNT_W'(LEN_SMALL); end
      TAG_LARGE: begin word = large_word;        len = CNT_W'(LEN_LARGE); end
      TAG_PATCH: begin word = large_word ^ mask; len = CNT_W'(LEN_PATCH); end
      default:   begin bad = 1'b1;               len = CNT_W'(TAG_W);     end
    endcase
  end
endmodule

// File: rtl/bmd_fifo.sv
module bmd_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] n_q;
  logic          pop;

  assign full      = (n_q == CW'(DEPTH));
  assign out_valid = (n_q != '0);
  assign pop       = out_valid && out_ready;
  assign dout      = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      rd_q <= '0;
      n_q  <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      n_q <= n_q + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/bmd_decomp.sv
module bmd_decomp
  import bmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 32,
  parameter int SIDX_W  = 4,
  parameter int LIDX_W  = 8,
  parameter int BUF_W   = 96,
  parameter int Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic              tbl_large,
  input  logic [LIDX_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] tbl_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err
);
  localparam int CNT_W  = $clog2(BUF_W + 1);
  localparam int HEAD_W = TAG_W + DATA_W;

  logic [BUF_W-1:0]  buf_bits;
  logic [CNT_W-1:0]  buf_cnt, need_len;
  logic [SIDX_W-1:0] s_idx;
  logic [LIDX_W-1:0] l_idx;
  logic [DATA_W-1:0] s_word, l_word, dec_word;
  logic              dec_bad, q_full, fire, q_push, bad_fire, err_q;

  bmd_inbuf #(.BUF_W(BUF_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_inbuf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .consume(fire), .take_len(need_len),
    .bits(buf_bits), .cnt(buf_cnt)
  );

  bmd_table #(.IDX_W(SIDX_W), .DATA_W(DATA_W)) u_small (
    .clk(clk), .we(tbl_we && !tbl_large), .waddr(tbl_addr[SIDX_W-1:0]),
    .wdata(tbl_data), .raddr(s_idx), .rdata(s_word)
  );

  bmd_table #(.IDX_W(LIDX_W), .DATA_W(DATA_W)) u_large (
    .clk(clk), .we(tbl_we && tbl_large), .waddr(tbl_addr),
    .wdata(tbl_data), .raddr(l_idx), .rdata(l_word)
  );

  bmd_decode #(.DATA_W(DATA_W), .SIDX_W(SIDX_W), .LIDX_W(LIDX_W),
               .CNT_W(CNT_W), .HEAD_W(HEAD_W)) u_dec (
    .head(buf_bits[BUF_W-1 -: HEAD_W]), .small_word(s_word),
    .large_word(l_word), .s_idx(s_idx), .l_idx(l_idx), .len(need_len),
    .word(dec_word), .bad(dec_bad)
  );

  assign fire     = (buf_cnt >= need_len) && !q_full;
  assign q_push   = fire && !dec_bad;
  assign bad_fire = fire && dec_bad;

  bmd_fifo #(.W(DATA_W), .DEPTH(Q_DEPTH)) u_oq (
    .clk(clk), .rst(rst), .push(q_push), .din(dec_word), .full(q_full),
    .out_valid(out_valid), .out_ready(out_ready), .dout(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst)           err_q <= 1'b0;
    else if (bad_fire) err_q <= 1'b1;
  end

  assign err = err_q;
endmodule

// File: rtl/bmd_checker.sv
module bmd_checker #(
  parameter int CNT_W  = 7,
  parameter int BUF_W  = 96,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err,
  input logic [CNT_W-1:0]  buf_cnt,
  input logic              q_full,
  input logic              q_push,
  input logic              bad_fire
);
  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !err));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    buf_cnt <= CNT_W'(BUF_W));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (rst)
    q_full |-> !q_push);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_bad_silent_R9: assert property (@(posedge clk) disable iff (rst)
    bad_fire |-> !q_push);
endmodule

bind bmd_decomp bmd_checker #(.CNT_W(CNT_W), .BUF_W(BUF_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .err(err), .buf_cnt(buf_cnt), .q_full(q_full),
  .q_push(q_push), .bad_fire(bad_fire)
);

// File: tb/tb_bmd_decomp.sv
`timescale 1ns/1ps
module tb_bmd_decomp;
  logic        clk = 1'b0;
  logic        rst;
  logic        tbl_we, tbl_large;
  logic [7:0]  tbl_addr;
  logic [31:0] tbl_data;
  logic        in_valid, in_ready;
  logic [31:0] in_data;
  logic        out_valid, out_ready;
  logic [31:0] out_data;
  logic        err;

  always #4 clk = ~clk;

  bmd_decomp dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_large(tbl_large),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .err(err)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int widx = 0, nwords = 0, oidx = 0, nexp = 0, nbits = 0;
  int rdymode = 0, gapmode = 0;
  logic [31:0] words [0:511];
  logic [31:0] expv  [0:1023];
  string       expt  [0:1023];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] sval(int i);
    return (32'(i) * 32'h0100_0193) ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] lval(int j);
    return (32'(j) * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_bits(logic [34:0] v, int n);
    for (int k = n - 1; k >= 0; k--) begin
      words[nbits / 32][31 - (nbits % 32)] = v[k];
      nbits++;
    end
    nwords = 0;
  endtask

  task automatic add_exp(logic [31:0] v, string t);
    expv[nexp] = v; expt[nexp] = t; nexp++;
  endtask

  task automatic add_raw(logic [31:0] x);      // R2
    put_bits({3'b000, x}, 35); add_exp(x, "R2 raw");
  endtask
  task automatic add_small(int i);             // R3
    put_bits(35'({3'b001, 4'(i)}), 7); add_exp(sval(i), "R3 small");
  endtask
  task automatic add_large(int j);             // R4
    put_bits(35'({3'b010, 8'(j)}), 11); add_exp(lval(j), "R4 large");
  endtask
  task automatic add_patch(int j, int p, int m); // R5
    put_bits(35'({3'b011, 8'(j), 2'(p), 2'(m)}), 15);
    add_exp(lval(j) ^ (32'(m) << (2 * p)), "R5 patch");
  endtask

  task automatic clear_stream();
    nwords = 0; nbits = 0; nexp = 0; oidx = 0; widx = 0;
    for (int k = 0; k < 512; k++) words[k] = '0;
  endtask

  // driver
  initial begin
    bit acc;
    in_valid = 0; in_data = '0;
    forever begin
      @(negedge clk);
      if (!rst && widx < nwords && !(gapmode != 0 && (cyc % 5) == 3)) begin
        in_valid = 1'b1; in_data = words[widx];
      end else begin
        in_valid = 1'b0;
      end
      #1 acc = in_valid && in_ready;
      @(posedge clk);
      if (acc) widx++;
    end
  end

  // monitor
  initial begin
    bit hold_prev = 0;
    logic [31:0] prev_data = '0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (rdymode == 0) ? 1'b1 : (rdymode == 2) ? 1'b0 : (lfsr[0] | lfsr[3]);
      #1;
      if (!rst) begin
        if (hold_prev)
          check(out_valid && out_data == prev_data, "R8 hold under back-pressure",
                out_data, prev_data);
        if (out_valid && out_ready) begin
          if (oidx < nexp) begin
            check(out_data == expv[oidx], {expt[oidx], " / R6 order"}, out_data, expv[oidx]);
            oidx++;
          end else begin
            check(1'b0, "R6 extra output", out_data, 32'h0);
          end
        end
        hold_prev = out_valid && !out_ready;
        prev_data = out_data;
      end else begin
        hold_prev = 0;
      end
      cyc++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    nwords = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    clear_stream();
    #2;
    check(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'h0);
    check(!err, "R1 err after reset", 32'(err), 32'h0);
    check(in_ready, "R1 in_ready after reset", 32'(in_ready), 32'h1);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic go(int nb);
    widx = 0; oidx = 0;
    nwords = (nb + 31) / 32;
  endtask

  task automatic wait_done(int lim, string req);
    int n = 0;
    while ((oidx < nexp || widx < nwords) && n < lim) begin
      @(negedge clk); n++;
    end
    check(oidx == nexp, req, 32'(oidx), 32'(nexp));
    repeat (20) @(negedge clk);
  endtask

  task automatic build_mixed();
    for (int i = 0; i < 256; i++) begin
      add_large(i);
      if (i < 16) add_small(15 - i);
      if ((i % 32) == 5) add_raw(32'hF00D_0000 + 32'(i * 7919));
      if (i < 64) add_patch((i * 37) % 256, i % 4, (i / 4) % 4);
    end
  endtask

  initial begin
    int sent_bits;
    rst = 1'b1; tbl_we = 0; tbl_large = 0; tbl_addr = '0; tbl_data = '0;
    do_reset();

    // R10: load both tables through the write port
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); tbl_we = 1; tbl_large = 0; tbl_addr = 8'(i); tbl_data = sval(i);
    end
    for (int j = 0; j < 256; j++) begin
      @(negedge clk); tbl_we = 1; tbl_large = 1; tbl_addr = 8'(j); tbl_data = lval(j);
    end
    @(negedge clk); tbl_we = 0;

    // Phase A: continuous stream, output always ready (R6 refill + consume together)
    rdymode = 0; gapmode = 0;
    build_mixed();
    go(nbits);
    wait_done(5000, "R6 all outputs, free-running");

    // Phase B: same stream with input gaps and random back-pressure (R8)
    do_reset();
    rdymode = 1; gapmode = 1;
    build_mixed();
    go(nbits);
    wait_done(10000, "R6 all outputs, back-pressure");

    // Phase D: output blocked, raw entries only (R7 fill limit, R8 stall)
    do_reset();
    rdymode = 2; gapmode = 0;
    for (int k = 0; k < 10; k++) add_raw(32'hA000_0000 + 32'(k * 32'h11111));
    go(nbits);
    repeat (60) @(negedge clk);
    #2;
    sent_bits = widx * 32 - 4 * 35;
    check(!in_ready, "R7 in_ready low when buffer full", 32'(in_ready), 32'h0);
    check(sent_bits >= 64 && sent_bits <= 95, "R7 buffered bit count in 64..95",
          32'(sent_bits), 32'd64);
    check(out_valid && oidx == 0, "R8 queue holds with output blocked", 32'(oidx), 32'h0);
    rdymode = 0;
    wait_done(2000, "R8 all outputs after release");

    // Phase C: reserved tag (R9)
    do_reset();
    rdymode = 0;
    add_small(3);
    put_bits(35'(3'b101), 3);
    add_small(5);
    go(nbits);
    wait_done(500, "R9 outputs around reserved tag");
    check(err, "R9 err set by reserved tag", 32'(err), 32'h1);
    repeat (5) @(negedge clk);
    #2;
    check(err, "R9 err sticky", 32'(err), 32'h1);
    do_reset();
    #2;
    check(!err, "R9 err cleared only by reset", 32'(err), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R6 watchdog: actual outputs %0d expected %0d", oidx, nexp);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule